// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the control word at management address 0 of an Ethernet transceiver. A simple register port (address, write data, write strobe, read strobe, read data) reaches it. It keeps the loopback, speed, auto-negotiation enable, power-down, isolate, duplex and collision-test fields. It turns writes of the two self-clearing bits into single-cycle pulses: one for software reset and one for restart of auto-negotiation.

Four strap inputs set the reset defaults of auto-negotiation enable, isolate, duplex and (optionally) speed. The block samples them again on every software reset. It drives the effective link speed and duplex: while auto-negotiation is enabled these come from the negotiated result, and otherwise from the register bits. Leaving power-down through software reset takes two reset writes. The first write only clears power-down, and the second write performs the reset.

Top module: `phy_ctrl_reg`

## Requirements
- R1: On hardware reset, aneg enable (bit 12) = `strap_aneg_i`, isolate (bit 10) = `strap_iso_i`, duplex (bit 8) = NOT `strap_duplex_i`, and speed (bit 13) = `strap_speed_i` when SPEED_STRAPPED = 1 (else SPEED_RESET). Loopback (bit 14), power-down (bit 11) and collision test (bit 7) reset to 0.
- R2: A write with bit 15 = 1 while power-down is 0 reloads every field from the current straps as in R1 and ignores the other written bits. `soft_rst_o` is 1 for exactly the one cycle that follows the write edge.
- R3: A write with bit 15 = 1 while power-down is 1 only clears power-down. It raises no `soft_rst_o` and leaves every other field unchanged.
- R4: A write (bit 15 = 0) with bit 9 = 1 and bit 12 = 1 raises `aneg_restart_o` for exactly one cycle after the write edge. With bit 12 = 0 in the written word, no pulse is raised.
- R5: Bits 15, 9 and 6..0 always read as 0, whatever was written.
- R6: A write with bit 15 = 0 stores bits 14, 13, 12, 11, 10, 8 and 7, and a later read returns them at the same positions.
- R7: With aneg enable = 1, `speed_100_o`/`full_duplex_o` follow `aneg_speed_i`/`aneg_duplex_i`. With aneg enable = 0, they follow bit 13 (1 = 100 Mb/s) and bit 8 (1 = full duplex).
- R8: `power_down_o`, `isolate_o`, `loopback_o` and `col_test_o` equal stored bits 11, 10, 14 and 7.
- R9: Writes to any address other than REG_ADDR leave the register unchanged. Reads of any other address return 0.
- R10: `rdata_o` takes the value selected by a read in the cycle after `rd_en_i`, and holds that value while `rd_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 16 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| strap_aneg_i | input | 1 | Strap: auto-negotiation enable default |
| strap_iso_i | input | 1 | Strap: isolate default |
| strap_duplex_i | input | 1 | Strap: inverted duplex default |
| strap_speed_i | input | 1 | Strap: speed default (SPEED_STRAPPED = 1) |
| aneg_speed_i | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| aneg_duplex_i | input | 1 | Negotiated duplex, 1 = full |
| soft_rst_o | output | 1 | One-cycle software reset pulse |
| aneg_restart_o | output | 1 | One-cycle auto-negotiation restart pulse |
| speed_100_o | output | 1 | Effective speed, 1 = 100 Mb/s |
| full_duplex_o | output | 1 | Effective duplex, 1 = full |
| power_down_o | output | 1 | Power-down control |
| isolate_o | output | 1 | Isolate from MAC interface |
| loopback_o | output | 1 | Loopback control |
| col_test_o | output | 1 | Collision test enable |

## Verification
The bench builds the block with its defaults: a 5-bit address, the register at address 0 and the speed default taken from a strap. With the speed strap in use, all four strap inputs can be toggled between a hardware reset and a software reset, so the re-sampling of every strap-derived field is observable. The 5-bit address leaves non-zero addresses free, and the bench uses them to show that writes there are ignored and reads there return zero.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int DATA_W    = 16;
  localparam int B_RST     = 15;
  localparam int B_LOOP    = 14;
  localparam int B_SPD     = 13;
  localparam int B_ANEG    = 12;
  localparam int B_PDN     = 11;
  localparam int B_ISO     = 10;
  localparam int B_RESTART = 9;
  localparam int B_DPX     = 8;
  localparam int B_COLT    = 7;

  typedef struct packed {
    logic loopback;
    logic speed;
    logic aneg_en;
    logic pdn;
    logic isolate;
    logic duplex;
    logic col_test;
  } ctrl_fields_t;

  function automatic logic [DATA_W-1:0] pack_fields(ctrl_fields_t f);
    logic [DATA_W-1:0] w;
    w         = '0;
    w[B_LOOP] = f.loopback;
    w[B_SPD]  = f.speed;
    w[B_ANEG] = f.aneg_en;
    w[B_PDN]  = f.pdn;
    w[B_ISO]  = f.isolate;
    w[B_DPX]  = f.duplex;
    w[B_COLT] = f.col_test;
    return w;
  endfunction

  function automatic ctrl_fields_t unpack_word(logic [DATA_W-1:0] w);
    ctrl_fields_t f;
    f.loopback = w[B_LOOP];
    f.speed    = w[B_SPD];
    f.aneg_en  = w[B_ANEG];
    f.pdn      = w[B_PDN];
    f.isolate  = w[B_ISO];
    f.duplex   = w[B_DPX];
    f.col_test = w[B_COLT];
    return f;
  endfunction
endpackage

// File: rtl/ctrl_field_store.sv
module ctrl_field_store
  import phy_ctrl_pkg::*;
#(
  parameter bit SPEED_STRAPPED = 1'b1,
  parameter bit SPEED_RESET    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              strap_aneg_i,
  input  logic              strap_iso_i,
  input  logic              strap_duplex_i,
  input  logic              strap_speed_i,
  output ctrl_fields_t      fields_o,
  output logic              soft_rst_o,
  output logic              restart_o
);
  logic         speed_dflt;
  ctrl_fields_t dflt;
  ctrl_fields_t fields_q;
  logic         soft_rst_q;
  logic         restart_q;

  generate
    if (SPEED_STRAPPED) begin : g_spd_strap
      assign speed_dflt = strap_speed_i;
    end else begin : g_spd_fixed
      assign speed_dflt = SPEED_RESET;
    end
  endgenerate

  always_comb begin
    dflt          = '0;
    dflt.speed    = speed_dflt;
    dflt.aneg_en  = strap_aneg_i;
    dflt.isolate  = strap_iso_i;
    dflt.duplex   = ~strap_duplex_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_q   <= dflt;
      soft_rst_q <= 1'b0;
      restart_q  <= 1'b0;
    end else begin
      soft_rst_q <= 1'b0;
      restart_q  <= 1'b0;
      if (wr_hit_i) begin
        if (wdata_i[B_RST]) begin
          if (fields_q.pdn) begin
            fields_q.pdn <= 1'b0;   // first reset write only wakes up
          end else begin
            fields_q   <= dflt;
            soft_rst_q <= 1'b1;
          end
        end else begin
          fields_q  <= unpack_word(wdata_i);
          restart_q <= wdata_i[B_RESTART] & wdata_i[B_ANEG];
        end
      end
    end
  end

  assign fields_o   = fields_q;
  assign soft_rst_o = soft_rst_q;
  assign restart_o  = restart_q;
endmodule

// File: rtl/ctrl_mode_resolve.sv
module ctrl_mode_resolve
  import phy_ctrl_pkg::*;
(
  input  ctrl_fields_t fields_i,
  input  logic         aneg_speed_i,
  input  logic         aneg_duplex_i,
  output logic         speed_100_o,
  output logic         full_duplex_o,
  output logic         power_down_o,
  output logic         isolate_o,
  output logic         loopback_o,
  output logic         col_test_o
);
  always_comb begin
    if (fields_i.aneg_en) begin
      speed_100_o   = aneg_speed_i;
      full_duplex_o = aneg_duplex_i;
    end else begin
      speed_100_o   = fields_i.speed;
      full_duplex_o = fields_i.duplex;
    end
  end

  assign power_down_o = fields_i.pdn;
  assign isolate_o    = fields_i.isolate;
  assign loopback_o   = fields_i.loopback;
  assign col_test_o   = fields_i.col_test;
endmodule

// File: rtl/ctrl_read_port.sv
module ctrl_read_port
  import phy_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              rd_hit_i,
  input  ctrl_fields_t      fields_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rd_hit_i ? pack_fields(fields_i) : '0;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 5,
  parameter int REG_ADDR       = 0,
  parameter bit SPEED_STRAPPED = 1'b1,
  parameter bit SPEED_RESET    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [15:0]       rdata_o,
  input  logic              strap_aneg_i,
  input  logic              strap_iso_i,
  input  logic              strap_duplex_i,
  input  logic              strap_speed_i,
  input  logic              aneg_speed_i,
  input  logic              aneg_duplex_i,
  output logic              soft_rst_o,
  output logic              aneg_restart_o,
  output logic              speed_100_o,
  output logic              full_duplex_o,
  output logic              power_down_o,
  output logic              isolate_o,
  output logic              loopback_o,
  output logic              col_test_o
);
  localparam logic [ADDR_W-1:0] REG_SEL = ADDR_W'(REG_ADDR);

  logic         addr_hit;
  ctrl_fields_t fields;

  assign addr_hit = (addr_i == REG_SEL);

  ctrl_field_store #(
    .SPEED_STRAPPED(SPEED_STRAPPED),
    .SPEED_RESET   (SPEED_RESET)
  ) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_hit_i      (wr_en_i & addr_hit),
    .wdata_i       (wdata_i),
    .strap_aneg_i  (strap_aneg_i),
    .strap_iso_i   (strap_iso_i),
    .strap_duplex_i(strap_duplex_i),
    .strap_speed_i (strap_speed_i),
    .fields_o      (fields),
    .soft_rst_o    (soft_rst_o),
    .restart_o     (aneg_restart_o)
  );

  ctrl_mode_resolve u_resolve (
    .fields_i     (fields),
    .aneg_speed_i (aneg_speed_i),
    .aneg_duplex_i(aneg_duplex_i),
    .speed_100_o  (speed_100_o),
    .full_duplex_o(full_duplex_o),
    .power_down_o (power_down_o),
    .isolate_o    (isolate_o),
    .loopback_o   (loopback_o),
    .col_test_o   (col_test_o)
  );

  ctrl_read_port u_read (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .rd_hit_i(addr_hit),
    .fields_i(fields),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/phy_ctrl_reg_chk.sv
module phy_ctrl_reg_chk #(
  parameter int ADDR_W   = 5,
  parameter int REG_ADDR = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       wdata_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [15:0]       rdata_o,
  input logic              soft_rst_o,
  input logic              aneg_restart_o,
  input logic              power_down_o,
  input logic              loopback_o,
  input logic              col_test_o
);
  localparam logic [ADDR_W-1:0] REG_SEL = ADDR_W'(REG_ADDR);

  a_r2_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  a_r2_rst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (!power_down_o && !loopback_o && !col_test_o));

  a_r3_pdn_wake_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_SEL && wdata_i[15] && power_down_o)
      |=> (!soft_rst_o && !power_down_o));

  a_r4_restart_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aneg_restart_o |=> !aneg_restart_o);

  a_r4_restart_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aneg_restart_o |-> $past(wr_en_i && addr_i == REG_SEL && wdata_i[9] && wdata_i[12] && !wdata_i[15]));

  a_r5_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == REG_SEL) |=> (rdata_o[15] == 1'b0 && rdata_o[9] == 1'b0 && rdata_o[6:0] == 7'd0));

  a_r9_other_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i != REG_SEL) |=> (rdata_o == 16'd0));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind phy_ctrl_reg phy_ctrl_reg_chk #(
  .ADDR_W  (ADDR_W),
  .REG_ADDR(REG_ADDR)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .wr_en_i       (wr_en_i),
  .rd_en_i       (rd_en_i),
  .rdata_o       (rdata_o),
  .soft_rst_o    (soft_rst_o),
  .aneg_restart_o(aneg_restart_o),
  .power_down_o  (power_down_o),
  .loopback_o    (loopback_o),
  .col_test_o    (col_test_o)
);

// File: tb/tb_phy_ctrl_reg.sv
`timescale 1ns/1ps
module tb_phy_ctrl_reg;
  localparam int ADDR_W = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [15:0]       wdata_i = '0;
  logic              wr_en_i = 1'b0;
  logic              rd_en_i = 1'b0;
  logic [15:0]       rdata_o;
  logic              strap_aneg_i = 1'b1;
  logic              strap_iso_i = 1'b0;
  logic              strap_duplex_i = 1'b0;
  logic              strap_speed_i = 1'b1;
  logic              aneg_speed_i = 1'b0;
  logic              aneg_duplex_i = 1'b0;
  logic              soft_rst_o, aneg_restart_o, speed_100_o, full_duplex_o;
  logic              power_down_o, isolate_o, loopback_o, col_test_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  phy_ctrl_reg #(.ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic hw_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  function automatic logic [15:0] outs();
    return {8'd0, soft_rst_o, aneg_restart_o, speed_100_o, full_duplex_o,
            power_down_o, isolate_o, loopback_o, col_test_o};
  endfunction

  task automatic t_reset_defaults();
    logic [15:0] d;
    strap_aneg_i = 1'b1; strap_iso_i = 1'b0; strap_duplex_i = 1'b0; strap_speed_i = 1'b1;
    hw_reset();
    rd(0, d);
    chk("R1 reset word", d, 16'h3100);
    chk("R1 reset outputs", outs(), 16'h0000);
    strap_aneg_i = 1'b0; strap_iso_i = 1'b1; strap_duplex_i = 1'b1; strap_speed_i = 1'b0;
    hw_reset();
    rd(0, d);
    chk("R1 alt strap word", d, 16'h0400);
    chk("R8 isolate after reset", outs(), 16'h0004);
  endtask

  task automatic t_rw_fields();
    logic [15:0] d;
    wr(0, 16'h6FFF);
    chk("R4 no restart aneg off", {15'd0, aneg_restart_o}, 16'h0);
    rd(0, d);
    chk("R6 fields stored", d, 16'h6D80);
    chk("R5 zero bits", d & 16'h827F, 16'h0000);
    chk("R7 R8 outputs", outs(), 16'h003F);
    wr(0, 16'h0000);
    rd(0, d);
    chk("R6 fields cleared", d, 16'h0000);
    chk("R7 R8 outputs clear", outs(), 16'h0000);
  endtask

  task automatic t_pdn_exit();
    logic [15:0] d;
    wr(0, 16'h4800);
    chk("R8 power down on", {15'd0, power_down_o}, 16'h1);
    wr(0, 16'hC000);
    chk("R3 no reset pulse", {15'd0, soft_rst_o}, 16'h0);
    rd(0, d);
    chk("R3 only pdn cleared", d, 16'h4000);
    strap_aneg_i = 1'b0; strap_iso_i = 1'b1; strap_duplex_i = 1'b1; strap_speed_i = 1'b0;
    wr(0, 16'hC280);
    chk("R2 reset pulse high", {15'd0, soft_rst_o}, 16'h1);
    @(negedge clk_i);
    chk("R2 reset pulse one cycle", {15'd0, soft_rst_o}, 16'h0);
    rd(0, d);
    chk("R2 straps resampled", d, 16'h0400);
    strap_aneg_i = 1'b1; strap_iso_i = 1'b0; strap_duplex_i = 1'b0; strap_speed_i = 1'b1;
    wr(0, 16'h8000);
    rd(0, d);
    chk("R2 second resample", d, 16'h3100);
  endtask

  task automatic t_restart();
    logic [15:0] d;
    wr(0, 16'h1200);
    chk("R4 restart pulse", {15'd0, aneg_restart_o}, 16'h1);
    @(negedge clk_i);
    chk("R4 restart one cycle", {15'd0, aneg_restart_o}, 16'h0);
    rd(0, d);
    chk("R5 restart reads 0", d, 16'h1000);
    wr(0, 16'h0200);
    chk("R4 restart suppressed", {15'd0, aneg_restart_o}, 16'h0);
  endtask

  task automatic t_effective();
    wr(0, 16'h1000);
    aneg_speed_i = 1'b1; aneg_duplex_i = 1'b0;
    #1 chk("R7 aneg result 10", {14'd0, speed_100_o, full_duplex_o}, 16'h2);
    aneg_speed_i = 1'b0; aneg_duplex_i = 1'b1;
    #1 chk("R7 aneg result 01", {14'd0, speed_100_o, full_duplex_o}, 16'h1);
    wr(0, 16'h2000);
    chk("R7 manual speed", {14'd0, speed_100_o, full_duplex_o}, 16'h2);
    wr(0, 16'h0100);
    chk("R7 manual duplex", {14'd0, speed_100_o, full_duplex_o}, 16'h1);
  endtask

  task automatic t_addr_decode();
    logic [15:0] d;
    wr(0, 16'h4080);
    wr(1, 16'h0800);
    wr(31, 16'h8000);
    chk("R9 other addr no pulse", {15'd0, soft_rst_o}, 16'h0);
    rd(0, d);
    chk("R9 write elsewhere ignored", d, 16'h4080);
    rd(5, d);
    chk("R9 read elsewhere zero", d, 16'h0000);
  endtask

  task automatic t_read_hold();
    logic [15:0] d;
    rd(0, d);
    wr(0, 16'h0400);
    @(negedge clk_i);
    chk("R10 holds without read", rdata_o, 16'h4080);
    rd(0, d);
    chk("R10 updated on read", d, 16'h0400);
  endtask

  initial begin
    t_reset_defaults();
    t_rw_fields();
    t_pdn_exit();
    t_restart();
    t_effective();
    t_addr_decode();
    t_read_hold();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule